// File: doc/BRIEF.md
# Oversampled Serial Byte Receiver with Even Parity

This block turns an asynchronous, idle-high serial line into bytes. Its clock runs at sixteen times the bit rate. A two-flop synchronizer cleans the line first. After a falling edge, an oversampling counter runs to the centre of the start bit and then keeps running, so each later bit is sampled sixteen clocks after the one before it. A frame carries a low start bit, eight data bits least significant first, one even-parity bit and a high stop bit.

Each data bit and the parity bit shift into a nine-bit register. When the stop bit samples high, the eight data bits move into a separate holding register, so the next frame can be received while the consumer still holds the last byte. The output side is a valid/ready stream. `byte_valid` is the valid and `rd_ack` is the ready. While `byte_valid` is high, `rx_byte` stays stable until a handshake or a newer byte. The serial line cannot be stalled, so there is no back-pressure toward it. A byte that is not taken before the next one completes is overwritten. The two error flags are sticky, and a read clears them. The whole receiver keeps to roughly thirty flip-flops.

Top module: `serial_byte_rx`

## Requirements
- R1: After reset `rx_byte` is 0x00 and `byte_valid`, `parity_err` and `frame_err` are 0. The receiver starts no frame until it has seen the line high.
- R2: For a frame with a high stop bit, the first data bit received becomes bit 0 of `rx_byte`, the eighth becomes bit 7, and `byte_valid` goes to 1.
- R3: A clock cycle with `rd_ack` high and no byte loading clears `byte_valid`, `parity_err` and `frame_err`. Without `rd_ack` the byte and all flags hold their values.
- R4: Parity is even. If the XOR of the eight data bits and the parity bit is 1, `parity_err` is set, and the byte is still delivered with `byte_valid` set.
- R5: If the stop bit samples low, `frame_err` is set, and `rx_byte` and `byte_valid` keep their previous values.
- R6: After a framing error the receiver ignores the line until it has returned high. A line held low, however long, starts no new frame.
- R7: A low pulse that has ended before the mid-start-bit sample (eight clocks after detection) is treated as a glitch. Nothing is received and the outputs do not change.
- R8: A frame may start right after the previous stop bit. If `byte_valid` is still set when a new byte completes, the new byte replaces the held one and `byte_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, sixteen times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| rd_ack | input | 1 | Ready: consumer takes the byte and clears all flags |
| rx_byte | output | 8 | Held received byte |
| byte_valid | output | 1 | Valid: a byte is waiting in the holding register |
| parity_err | output | 1 | Sticky even-parity failure |
| frame_err | output | 1 | Sticky stop-bit failure |

## Verification
A wrong oversampling count or bit count shows up within one frame: the byte comes out shifted or rotated, or a parity error appears on a frame that was sent clean. A stuck frame state machine shows up after the next framing error. Either the break gets decoded as a byte, or the following good frame is lost. Stale or wrongly cleared flags show on the ports in the first check that follows a read or a bad frame. Random frames mixed with parity and stop faults expose each of these within a few frames.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [2:0] {
    RX_WAIT_HIGH = 3'd0,
    RX_IDLE      = 3'd1,
    RX_START     = 3'd2,
    RX_DATA      = 3'd3,
    RX_STOP      = 3'd4
  } rx_state_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pipe_q <= '1;
    else        pipe_q <= {pipe_q[STAGES-2:0], din};
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer
  import srx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int FRAME_BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic shift_en,
  output logic load_ok,
  output logic frame_bad
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] FINAL_BIT = BIT_W'(FRAME_BITS - 1);

  rx_state_t        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BIT_W-1:0] bit_q;
  logic             tick;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= RX_WAIT_HIGH;
      cnt_q   <= '0;
      bit_q   <= '0;
    end else begin
      unique case (state_q)
        RX_WAIT_HIGH: if (line) state_q <= RX_IDLE;
        RX_IDLE: begin
          cnt_q <= '0;
          if (!line) state_q <= RX_START;
        end
        RX_START: begin
          if (cnt_q == MID) begin
            cnt_q <= '0;
            bit_q <= '0;
            state_q <= line ? RX_IDLE : RX_DATA;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        RX_DATA: begin
          cnt_q <= cnt_q + 1'b1;
          if (tick) begin
            bit_q <= bit_q + 1'b1;
            if (bit_q == FINAL_BIT) state_q <= RX_STOP;
          end
        end
        RX_STOP: begin
          cnt_q <= cnt_q + 1'b1;
          if (tick) state_q <= line ? RX_IDLE : RX_WAIT_HIGH;
        end
        default: state_q <= RX_WAIT_HIGH;
      endcase
    end
  end

  assign shift_en  = (state_q == RX_DATA) && tick;
  assign load_ok   = (state_q == RX_STOP) && tick && line;
  assign frame_bad = (state_q == RX_STOP) && tick && !line;

  // R6: a low line never leaves the wait state
  a_r6_wait_for_high: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_WAIT_HIGH && !line) |=> (state_q == RX_WAIT_HIGH));

  // R7: high at mid-start returns to idle
  a_r7_glitch_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_START && cnt_q == MID && line) |=> (state_q == RX_IDLE));

  // R2: the bit count never runs past the frame
  a_r2_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DATA) |-> (bit_q <= FINAL_BIT));
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter #(
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] frame
);
  logic [WIDTH-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        sh_q <= '0;
    else if (shift_en) sh_q <= {din, sh_q[WIDTH-1:1]};
  end

  assign frame = sh_q;

  // R2: the register is steady between samples
  a_r2_shift_only_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(sh_q));
endmodule

// File: rtl/rx_holding.sv
module rx_holding #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              frame_bad,
  input  logic              ack,
  input  logic [DATA_W:0]   frame,
  output logic [DATA_W-1:0] byte_out,
  output logic              valid,
  output logic              perr,
  output logic              ferr
);
  logic [DATA_W-1:0] byte_q;
  logic              valid_q, perr_q, ferr_q;
  logic              par_bad;

  assign par_bad = ^frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_q  <= '0;
      valid_q <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      if (load) byte_q <= frame[DATA_W-1:0];
      valid_q <= load | (valid_q & ~ack);
      perr_q  <= (load & par_bad) | (perr_q & ~ack);
      ferr_q  <= frame_bad | (ferr_q & ~ack);
    end
  end

  assign byte_out = byte_q;
  assign valid    = valid_q;
  assign perr     = perr_q;
  assign ferr     = ferr_q;

  // R3: a read with no load clears valid
  a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !load) |=> !valid_q);

  // R2: held byte stays put without a load
  a_r2_byte_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(byte_q));

  // R4: bad parity flagged on the load
  a_r4_parity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (load && par_bad) |=> (perr_q && valid_q));

  // R5: framing fault keeps the byte and raises the flag
  a_r5_frame_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> ($stable(byte_q) && ferr_q));

  // R8: a load always leaves the new byte valid
  a_r8_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (valid_q && byte_q == $past(frame[DATA_W-1:0])));
endmodule

// File: rtl/serial_byte_rx.sv
module serial_byte_rx #(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_line,
  input  logic              rd_ack,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic              parity_err,
  output logic              frame_err
);
  localparam int FRAME_BITS = DATA_W + 1;

  logic             line_s;
  logic             shift_en, load_ok, frame_bad;
  logic [DATA_W:0]  frame;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_line), .dout(line_s)
  );

  rx_bit_timer #(.OVERSAMPLE(OVERSAMPLE), .FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst_n(rst_n), .line(line_s),
    .shift_en(shift_en), .load_ok(load_ok), .frame_bad(frame_bad)
  );

  rx_shifter #(.WIDTH(FRAME_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(line_s), .frame(frame)
  );

  rx_holding #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(load_ok), .frame_bad(frame_bad),
    .ack(rd_ack), .frame(frame), .byte_out(rx_byte), .valid(byte_valid),
    .perr(parity_err), .ferr(frame_err)
  );

  // R5: a frame ends in a load or a framing fault, never both
  a_r5_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_ok, frame_bad}));
endmodule

// File: tb/sim_serial_byte_rx.sv
module sim_serial_byte_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_byte;
  logic       byte_valid, parity_err, frame_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_byte = 8'h00;
  logic       exp_valid = 1'b0, exp_perr = 1'b0, exp_ferr = 1'b0;

  always #4 clk = ~clk;

  serial_byte_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rd_ack(rd_ack),
    .rx_byte(rx_byte), .byte_valid(byte_valid),
    .parity_err(parity_err), .frame_err(frame_err)
  );

  function automatic logic even_par(input logic [7:0] b);
    return ^b;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    check({req, " byte"},  rx_byte,           exp_byte);
    check({req, " valid"}, {7'd0, byte_valid}, {7'd0, exp_valid});
    check({req, " perr"},  {7'd0, parity_err}, {7'd0, exp_perr});
    check({req, " ferr"},  {7'd0, frame_err},  {7'd0, exp_ferr});
  endtask

  task automatic hold_bit(input logic v);
    rx_line = v;
    repeat (16) @(negedge clk);
  endtask

  // sends one frame; bad_stop leaves the line low afterwards
  task automatic send(input logic [7:0] b, input logic bad_par, input logic bad_stop);
    hold_bit(1'b0);
    for (int i = 0; i < 8; i++) hold_bit(b[i]);
    hold_bit(even_par(b) ^ bad_par);
    hold_bit(~bad_stop);
    if (bad_stop) begin
      exp_ferr = 1'b1;
    end else begin
      exp_byte  = b;
      exp_valid = 1'b1;
      if (bad_par) exp_perr = 1'b1;
    end
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic ack;
    rd_ack = 1'b1;
    @(negedge clk);
    rd_ack = 1'b0;
    exp_valid = 1'b0; exp_perr = 1'b0; exp_ferr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    idle(20);
    check_all("R1 after reset idle");

    // R2 basic frames, LSB first
    send(8'hA5, 1'b0, 1'b0); idle(20); check_all("R2 byte A5");
    send(8'h01, 1'b0, 1'b0); idle(20); check_all("R8 overwrite 01");
    ack(); check_all("R3 ack clears");

    // R4 parity error
    send(8'h3C, 1'b1, 1'b0); idle(20); check_all("R4 bad parity");
    idle(40); check_all("R3 flags hold without ack");
    ack(); check_all("R3 ack clears perr");

    // R5 and R6: bad stop, then long break
    send(8'h80, 1'b0, 1'b0); idle(20);
    send(8'h55, 1'b0, 1'b1);
    rx_line = 1'b0; repeat (200) @(negedge clk);
    check_all("R5 frame error keeps byte");
    idle(40); check_all("R6 no frame during break");
    send(8'hC3, 1'b0, 1'b0); idle(20); check_all("R6 recovers after high");
    ack();

    // R7 glitch
    rx_line = 1'b0; repeat (4) @(negedge clk);
    idle(60); check_all("R7 glitch ignored");
    send(8'h7E, 1'b0, 1'b0); idle(20); check_all("R7 frame after glitch");

    // R8 back-to-back frames without ack
    send(8'h12, 1'b0, 1'b0);
    send(8'hE7, 1'b0, 1'b0); idle(20); check_all("R8 back-to-back overwrite");
    ack();

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [7:0] b;
      logic bp, bs;
      b  = 8'($urandom);
      bp = ($urandom % 4) == 0;
      bs = ($urandom % 8) == 0;
      send(b, bp, bs);
      if (bs) begin
        rx_line = 1'b0; repeat (30) @(negedge clk);
      end
      idle(20);
      check_all("R2 random frame");
      if ($urandom % 2) begin
        ack();
        check_all("R3 random ack");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule